// File: doc/BRIEF.md
# Quad-Phase Time-over-Threshold TDC Channel

This block digitises one thresholded detector pulse stream. Once per 4 ns system cycle it takes a 4-bit vector of discriminator samples. The samples come from the two edges of two quadrature clocks, so together they cover the cycle in 1 ns steps. The channel finds where each pulse goes above threshold and where it drops back below. It then issues one hit record per pulse, holding the leading-edge time and the time-over-threshold width, both with a 1 ns LSB.

Pulses arrive continuously and are handled back to back. A new pulse may begin on the sample right after the previous one ended, including inside the same vector. Records leave through a valid/ready output. A single output register holds a record while the consumer stalls. Any record that cannot be kept is counted rather than queued.

Top module: `tot_tdc_channel`

## Requirements
- R1: A synchronous reset clears the cycle counter, the pulse state and the drop counter. During and right after reset `rec_valid_o` is 0 and `drop_cnt_o` is 0. The channel leaves reset as if the input had been low.
- R2: Bit 0 of `samp_i` is the earliest sample of a cycle and bit 3 the latest, 1 ns apart. For the k-th cycle after reset release (k counted from 0), sample bit i has time 4*k+i. `rec_time_o` is the time of the first high sample of the pulse.
- R3: `rec_width_o` is the time of the first low sample after the pulse minus the time of its first high sample. This holds both for a pulse contained within one vector and for a pulse that spans cycles. `rec_ovf_o` is 0 for such a record.
- R4: A pulse that starts on the sample directly after the end of the previous one produces its own record with its own timestamp.
- R5: If 256 consecutive samples starting at the leading edge are all high, a record with width 255 and `rec_ovf_o`=1 is produced for the cycle holding the 256th sample. No further record follows until the input has gone low and risen again. A pulse that falls exactly 255 ns after its start gives width 255 with `rec_ovf_o`=0.
- R6: A record becomes valid on the clock edge that ends the vector that completes the pulse. While `rec_valid_o`=1 and `rec_ready_i`=0, the record stays unchanged and valid.
- R7: A completed record that arrives while a record is held and `rec_ready_i` is low is discarded. `drop_cnt_o` is incremented by one, and the held record is unchanged.
- R8: When one vector completes two pulses, the earlier one is offered as a record and the later one is discarded and counted in `drop_cnt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 250 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_i | input | 4 | Discriminator samples of this cycle, bit 0 earliest |
| rec_ready_i | input | 1 | Consumer accepts the record |
| rec_valid_o | output | 1 | Record present |
| rec_time_o | output | 30 | Leading-edge time in ns (cycle count * 4 + phase) |
| rec_width_o | output | 8 | Time over threshold in ns |
| rec_ovf_o | output | 1 | Width saturated at 255 |
| drop_cnt_o | output | 16 | Number of discarded records, wrapping |

## Verification
An error in the phase state shows at the ports on the next record. A missed or extra transition gives a timestamp shifted by whole nanoseconds, or a record that is missing or doubled, in the cycle after the completing vector. A wrong width count only shows when the pulse ends, or 256 ns after it started for a saturated pulse. The cycle counter shows on every timestamp. A skid or drop error shows in the first stalled cycle that overlaps a completed pulse.

// File: rtl/tot_tdc_channel.sv
module tot_tdc_channel #(
  parameter int COARSE_W = 28,
  parameter int WIDTH_W  = 8,
  parameter int DROP_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3:0]            samp_i,
  input  logic                  rec_ready_i,
  output logic                  rec_valid_o,
  output logic [COARSE_W+1:0]   rec_time_o,
  output logic [WIDTH_W-1:0]    rec_width_o,
  output logic                  rec_ovf_o,
  output logic [DROP_W-1:0]     drop_cnt_o
);
  localparam int PH   = 4;
  localparam int FW   = 2;
  localparam int TS_W = COARSE_W + FW;
  localparam logic [WIDTH_W-1:0] WMAX = {WIDTH_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_HIGH, S_WAIT} st_t;

  logic [COARSE_W-1:0] coarse_q;
  st_t                 st_q, st_n;
  logic [TS_W-1:0]     lead_q, lead_n;
  logic [WIDTH_W-1:0]  w_q, w_n;

  logic                nrec, extra, done, dovf;
  logic [TS_W-1:0]     rts, t;
  logic [WIDTH_W-1:0]  rw, dw, wi;
  logic                rovf;

  always_comb begin
    st_n = st_q; lead_n = lead_q; w_n = w_q;
    nrec = 1'b0; extra = 1'b0;
    rts = '0; rw = '0; rovf = 1'b0;
    done = 1'b0; dw = '0; dovf = 1'b0; wi = '0; t = '0;
    for (int i = 0; i < PH; i++) begin
      done = 1'b0; dw = '0; dovf = 1'b0;
      t  = {coarse_q, FW'(i)};
      wi = w_n + 1'b1;
      case (st_n)
        S_IDLE: if (samp_i[i]) begin
          st_n = S_HIGH; lead_n = t; w_n = '0;
        end
        S_HIGH: begin
          if (!samp_i[i]) begin
            done = 1'b1; dw = wi; st_n = S_IDLE;
          end else if (wi == WMAX) begin
            done = 1'b1; dw = WMAX; dovf = 1'b1; st_n = S_WAIT;
          end else begin
            w_n = wi;
          end
        end
        default: if (!samp_i[i]) st_n = S_IDLE;
      endcase
      if (done) begin
        if (!nrec) begin
          nrec = 1'b1; rts = lead_n; rw = dw; rovf = dovf;
        end else begin
          extra = 1'b1;
        end
      end
    end
  end

  wire take = !rec_valid_o || rec_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_q    <= '0;
      st_q        <= S_IDLE;
      lead_q      <= '0;
      w_q         <= '0;
      rec_valid_o <= 1'b0;
      rec_time_o  <= '0;
      rec_width_o <= '0;
      rec_ovf_o   <= 1'b0;
      drop_cnt_o  <= '0;
    end else begin
      coarse_q <= coarse_q + 1'b1;
      st_q     <= st_n;
      lead_q   <= lead_n;
      w_q      <= w_n;
      if (take) begin
        rec_valid_o <= nrec;
        if (nrec) begin
          rec_time_o  <= rts;
          rec_width_o <= rw;
          rec_ovf_o   <= rovf;
        end
      end
      drop_cnt_o <= drop_cnt_o + DROP_W'(extra) + DROP_W'(nrec && !take);
    end
  end
endmodule

// File: rtl/tot_tdc_channel_chk.sv
module tot_tdc_channel_chk #(
  parameter int COARSE_W = 28,
  parameter int WIDTH_W  = 8,
  parameter int DROP_W   = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                rec_ready_i,
  input logic                rec_valid_o,
  input logic [COARSE_W+1:0] rec_time_o,
  input logic [WIDTH_W-1:0]  rec_width_o,
  input logic                rec_ovf_o,
  input logic [DROP_W-1:0]   drop_cnt_o
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!rec_valid_o && drop_cnt_o == '0));

  a_r5_ovf_width: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && rec_ovf_o) |-> (rec_width_o == {WIDTH_W{1'b1}}));

  a_r3_width_nonzero: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && !rec_ovf_o) |-> (rec_width_o != '0));

  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && !rec_ready_i) |=>
      (rec_valid_o && $stable(rec_time_o) && $stable(rec_width_o) && $stable(rec_ovf_o)));

  a_r7_drop_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (DROP_W'(drop_cnt_o - $past(drop_cnt_o)) <= DROP_W'(2)));
endmodule

bind tot_tdc_channel tot_tdc_channel_chk #(
  .COARSE_W(COARSE_W), .WIDTH_W(WIDTH_W), .DROP_W(DROP_W)
) chk_i (
  .clk(clk), .rst(rst), .rec_ready_i(rec_ready_i), .rec_valid_o(rec_valid_o),
  .rec_time_o(rec_time_o), .rec_width_o(rec_width_o), .rec_ovf_o(rec_ovf_o),
  .drop_cnt_o(drop_cnt_o)
);

// File: tb/tot_tdc_channel_tb_top.sv
module tot_tdc_channel_tb_top;
  localparam int CW = 28;
  localparam int WW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] samp = 4'h0;
  logic rdy = 1'b0;
  logic rec_valid, rec_ovf;
  logic [CW+1:0] rec_time;
  logic [WW-1:0] rec_width;
  logic [DW-1:0] drop_cnt;

  always #10 clk = ~clk;

  tot_tdc_channel #(.COARSE_W(CW), .WIDTH_W(WW), .DROP_W(DW)) dut_i (
    .clk(clk), .rst(rst), .samp_i(samp), .rec_ready_i(rdy),
    .rec_valid_o(rec_valid), .rec_time_o(rec_time), .rec_width_o(rec_width),
    .rec_ovf_o(rec_ovf), .drop_cnt_o(drop_cnt)
  );

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit finished = 0;

  int     m_st = 0;
  longint m_lead = 0;
  longint cyc = 0;
  bit     m_v = 0;
  longint m_ts = 0;
  longint m_w = 0;
  bit     m_ovf = 0;
  longint m_drop = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("valid", longint'(rec_valid), longint'(m_v));
    if (m_v) begin
      chk("time", longint'(rec_time), m_ts % (longint'(1) << (CW + 2)));
      chk("width", longint'(rec_width), m_w);
      chk("ovf", longint'(rec_ovf), longint'(m_ovf));
    end
    chk("drops", longint'(drop_cnt), m_drop % 65536);
  endtask

  task automatic step(input logic [3:0] s, input logic r);
    int n; int extra; longint fts; longint fw; bit fo; bit take; longint t;
    n = 0; extra = 0; fts = 0; fw = 0; fo = 0;
    compare();
    samp = s;
    rdy  = r;
    for (int i = 0; i < 4; i++) begin
      t = cyc * 4 + i;
      if (m_st == 0) begin
        if (s[i]) begin m_st = 1; m_lead = t; end
      end else if (m_st == 1) begin
        if (!s[i] || (t - m_lead == 255)) begin
          if (n == 0) begin fts = m_lead; fw = t - m_lead; fo = s[i]; end
          else extra++;
          n++;
          m_st = s[i] ? 2 : 0;
        end
      end else if (!s[i]) begin
        m_st = 0;
      end
    end
    take = !m_v || r;
    if (take) begin
      m_v = (n > 0);
      if (n > 0) begin m_ts = fts; m_w = fw; m_ovf = fo; end
    end else if (n > 0) begin
      m_drop++;
    end
    m_drop += extra;
    cyc++;
    @(negedge clk);
  endtask

  task automatic pulse(input int phase, input int len, input logic r);
    int ncyc; logic [3:0] v; int idx;
    ncyc = (phase + len) / 4 + 3;
    for (int c = 0; c < ncyc; c++) begin
      for (int i = 0; i < 4; i++) begin
        idx = c * 4 + i;
        v[i] = (idx >= phase) && (idx < phase + len);
      end
      step(v, r);
    end
  endtask

  task automatic adv();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    chk("valid in reset", longint'(rec_valid), 0);
    chk("drops in reset", longint'(drop_cnt), 0);
    rst = 1'b0;
    step(4'h0, 1'b1);
    step(4'h0, 1'b1);

    // R2 R3 R4 R8: every pair of vectors, then quiet
    tag = "R2/R3/R4/R8";
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        step(4'(a), 1'b1);
        step(4'(b), 1'b1);
        step(4'h0, 1'b1);
      end
    end

    // R5: widths around the saturation point, all phases
    tag = "R5";
    for (int len = 250; len <= 262; len++) begin
      for (int ph = 0; ph < 4; ph++) pulse(ph, len, 1'b1);
    end
    pulse(1, 700, 1'b1);

    // R7: long stall with several pulses
    tag = "R7";
    pulse(0, 3, 1'b0);
    pulse(2, 5, 1'b0);
    pulse(1, 1, 1'b0);
    step(4'h0, 1'b1);
    step(4'h0, 1'b1);

    // R6 R7 R8: pseudo-random samples and ready
    tag = "R6/R7/R8";
    for (int k = 0; k < 4000; k++) begin
      adv();
      if (lfsr[9]) step({4{lfsr[2]}}, lfsr[12] | lfsr[13]);
      else         step(lfsr[3:0], lfsr[12] | lfsr[13]);
    end
    step(4'h0, 1'b1);
    step(4'h0, 1'b1);
    compare();

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule